// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block turns one command into the control strobes of a single bus cycle of an 8-bit-data processor with a 16-bit address. A command port takes a cycle kind, an address and a write byte while the block is idle. The block then steps through its clock states and drives the active-low memory request, I/O request, read, write, first-cycle and refresh strobes, together with the address and the write data. A ready input, active low, stretches the cycle by one wait state for each clock it is seen low, with no upper limit. When the cycle has finished, the block returns the captured read byte with a one-clock done pulse.

An opcode fetch ends with a refresh slot. In that slot the low seven address bits carry an internal refresh count, which advances once per fetch. The first-cycle strobe tells an interrupt acknowledge, which raises I/O request together with it, apart from ordinary I/O, which never raises it. Between cycles a bus-release input turns off the address, data and shared-strobe drive enables so that another master can take the bus.

Top module: `bcs_bus_seq`

## Requirements
- R1: After reset all strobes are high, done is low, rdata and addr_o are zero, the refresh count is zero, addr_o and the strobes are enabled, and cmd_ready is high.
- R2: Kind code 0 (opcode fetch) lasts T1, T2, any wait states, T3 and T4. mreq_n, rd_n and m1_n are low from T1 through the last state before T3, and addr_o shows the command address.
- R3: In T3 and T4 of a fetch, rfsh_n and mreq_n are low and rd_n and m1_n are high. addr_o[6:0] holds the refresh count and addr_o[15:7] keep the command address. The count rises by one after every fetch and wraps from 127 to 0.
- R4: Kind 1 (memory read) and kind 2 (memory write) last T1, T2, any waits and T3, with mreq_n low throughout. A read holds rd_n low throughout. A write holds wr_n low from T2 and drives data_o with data_oe high from T1.
- R5: Kind 3 (I/O read) and kind 4 (I/O write) last T1, T2, any waits, T3 and T4. No strobe is low in T1. From T2 on, iorq_n is low with rd_n (kind 3) or wr_n (kind 4), and m1_n stays high. A write drives data_o with data_oe high from T1.
- R6: Kind 5 (interrupt acknowledge) lasts T1, T2, any waits, T3 and T4. m1_n is low throughout, iorq_n is low from T2, and rd_n and wr_n stay high.
- R7: Each clock edge that ends T2 or a wait state with wait_n low adds one more wait state. Every strobe and the address are held at their T2 values, with no limit on the count.
- R8: done is high for exactly the one clock after the last state of a cycle. rdata then holds data_i as sampled at the edge where the read strobe ends: the end of the data phase of a fetch, the end of T3 for kind 1, and the end of T4 for kinds 3 and 5.
- R9: While idle with bus_release high, addr_oe, strobe_oe, data_oe and cmd_ready are low, and a pending command does not start.
- R10: Kind codes 6 and 7 are ignored. No strobe goes low, done stays low and addr_o keeps its previous value.
- R11: rd_n and wr_n are never low together, and iorq_n is never low with rd_n or wr_n while m1_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and bus not released; command accepted when both valid and ready |
| cmd_kind | input | 3 | Cycle kind code (0 to 5; 6 and 7 ignored) |
| cmd_addr | input | 16 | Cycle address |
| cmd_wdata | input | 8 | Byte to write |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Captured read byte or interrupt vector |
| bus_release | input | 1 | Request to float the bus between cycles |
| wait_n | input | 1 | Active-low wait request |
| data_i | input | 8 | Data bus input |
| addr_o | output | 16 | Address bus |
| addr_oe | output | 1 | Address drive enable |
| data_o | output | 8 | Data bus output |
| data_oe | output | 1 | Data drive enable |
| mreq_n | output | 1 | Memory request, active low |
| iorq_n | output | 1 | I/O request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | First-cycle marker, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| strobe_oe | output | 1 | Drive enable for mreq_n, iorq_n, rd_n and wr_n |

## Verification
A command presented before a rising edge is accepted at that edge, so T1 strobes show one clock later. Each following state adds one clock, and each clock seen with wait_n low adds one more. done and the captured rdata are due in the clock after the last state. The bench builds the expected state list for every cycle from its kind and the wait count it drives. It samples the outputs at the falling edge in each of those clocks, so every strobe pattern, address and data value is compared in the exact clock it is due.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_INTA  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  localparam int unsigned KIND_LAST = 5;

  function automatic logic kind_has_t4(kind_e k);
    return (k != K_MRD) && (k != K_MWR);
  endfunction

endpackage

// File: rtl/bcs_phase_ctrl.sv
module bcs_phase_ctrl
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  kind_e  cmd_kind,
  input  logic   wait_n,
  output phase_e phase_q,
  output kind_e  kind_q,
  output logic   cap_en,
  output logic   rfsh_adv,
  output logic   done_q
);

  phase_e phase_d;
  logic   last_state;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = wait_n ? PH_T3 : PH_TW;
      PH_TW:   phase_d = wait_n ? PH_T3 : PH_TW;
      PH_T3:   phase_d = kind_has_t4(kind_q) ? PH_T4 : PH_IDLE;
      PH_T4:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    last_state = (phase_q == PH_T4) ||
                 ((phase_q == PH_T3) && !kind_has_t4(kind_q));
    rfsh_adv   = (phase_q == PH_T4) && (kind_q == K_FETCH);
    case (kind_q)
      K_FETCH: cap_en = ((phase_q == PH_T2) || (phase_q == PH_TW)) && wait_n;
      K_MRD:   cap_en = (phase_q == PH_T3);
      K_IORD,
      K_INTA:  cap_en = (phase_q == PH_T4);
      default: cap_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= K_FETCH;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= last_state;
      if (start) kind_q <= cmd_kind;
    end
  end

endmodule

// File: rtl/bcs_strobe_dec.sv
module bcs_strobe_dec
  import bcs_pkg::*;
(
  input  phase_e phase_q,
  input  kind_e  kind_q,
  output logic   mreq,
  output logic   iorq,
  output logic   rd,
  output logic   wr,
  output logic   m1,
  output logic   rfsh,
  output logic   drive_data,
  output logic   rfsh_slot
);

  logic data_ph;
  logic late_ph;
  logic busy;

  always_comb begin
    busy    = (phase_q != PH_IDLE);
    data_ph = (phase_q == PH_T1) || (phase_q == PH_T2) || (phase_q == PH_TW);
    late_ph = (phase_q == PH_T3) || (phase_q == PH_T4);
    mreq = 1'b0; iorq = 1'b0; rd = 1'b0; wr = 1'b0; m1 = 1'b0; rfsh = 1'b0;
    drive_data = 1'b0;
    rfsh_slot  = 1'b0;
    if (busy) begin
      case (kind_q)
        K_FETCH: begin
          mreq      = 1'b1;
          rd        = data_ph;
          m1        = data_ph;
          rfsh      = late_ph;
          rfsh_slot = late_ph;
        end
        K_MRD: begin
          mreq = 1'b1;
          rd   = 1'b1;
        end
        K_MWR: begin
          mreq       = 1'b1;
          wr         = (phase_q != PH_T1);
          drive_data = 1'b1;
        end
        K_IORD: begin
          iorq = (phase_q != PH_T1);
          rd   = (phase_q != PH_T1);
        end
        K_IOWR: begin
          iorq       = (phase_q != PH_T1);
          wr         = (phase_q != PH_T1);
          drive_data = 1'b1;
        end
        K_INTA: begin
          m1   = 1'b1;
          iorq = (phase_q != PH_T1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bcs_refresh_ctr.sv
module bcs_refresh_ctr #(
  parameter int unsigned RFSH_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [RFSH_W-1:0] count_q
);

  logic [RFSH_W-1:0] count_d;

  always_comb count_d = count_q + RFSH_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (adv) count_q <= count_d;
  end

endmodule

// File: rtl/bcs_data_path.sv
module bcs_data_path #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_in;
  end

endmodule

// File: rtl/bcs_bus_seq.sv
module bcs_bus_seq
  import bcs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned RFSH_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              bus_release,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m1_n,
  output logic              rfsh_n,
  output logic              strobe_oe
);

  localparam int unsigned HI_W = ADDR_W - RFSH_W;

  logic [SYNC_STAGES-1:0] rst_sr;
  logic                   rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_sr[SYNC_STAGES-1];

  phase_e            phase_q;
  kind_e             kind_q;
  logic              cap_en, rfsh_adv, start, kind_ok, bus_off;
  logic              mreq, iorq, rd, wr, m1, rfsh, drive_data, rfsh_slot;
  logic [RFSH_W-1:0] rcount;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    kind_ok   = (cmd_kind <= 3'(KIND_LAST));
    bus_off   = (phase_q == PH_IDLE) && bus_release;
    cmd_ready = (phase_q == PH_IDLE) && !bus_release;
    start     = cmd_valid && cmd_ready && kind_ok;
  end

  bcs_phase_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .cmd_kind (kind_e'(cmd_kind)),
    .wait_n   (wait_n),
    .phase_q  (phase_q),
    .kind_q   (kind_q),
    .cap_en   (cap_en),
    .rfsh_adv (rfsh_adv),
    .done_q   (done)
  );

  bcs_strobe_dec dec_i (
    .phase_q    (phase_q),
    .kind_q     (kind_q),
    .mreq       (mreq),
    .iorq       (iorq),
    .rd         (rd),
    .wr         (wr),
    .m1         (m1),
    .rfsh       (rfsh),
    .drive_data (drive_data),
    .rfsh_slot  (rfsh_slot)
  );

  bcs_refresh_ctr #(.RFSH_W(RFSH_W)) rctr_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .adv     (rfsh_adv),
    .count_q (rcount)
  );

  bcs_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (start),
    .addr_in  (cmd_addr),
    .wdata_in (cmd_wdata),
    .cap_en   (cap_en),
    .bus_in   (data_i),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .rdata_q  (rdata)
  );

  always_comb begin
    addr_o    = rfsh_slot ? {addr_q[ADDR_W-1 -: HI_W], rcount} : addr_q;
    addr_oe   = !bus_off;
    strobe_oe = !bus_off;
    data_o    = wdata_q;
    data_oe   = drive_data;
    mreq_n    = !mreq;
    iorq_n    = !iorq;
    rd_n      = !rd;
    wr_n      = !wr;
    m1_n      = !m1;
    rfsh_n    = !rfsh;
  end

endmodule

// File: rtl/bcs_bus_seq_chk.sv
module bcs_bus_seq_chk
  import bcs_pkg::*;
#(
  parameter int unsigned RFSH_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic              wait_n,
  input logic              bus_release,
  input logic              done,
  input logic [RFSH_W-1:0] addr_lo,
  input logic              addr_oe,
  input logic              strobe_oe,
  input logic              data_oe,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              m1_n,
  input logic              rfsh_n
);

  logic [RFSH_W-1:0] last_rfsh;
  logic              seen_rfsh;
  logic              rfsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rfsh <= '0;
      seen_rfsh <= 1'b0;
      rfsh_q    <= 1'b1;
    end else begin
      rfsh_q <= rfsh_n;
      if (!rfsh_n && rfsh_q) begin
        last_rfsh <= addr_lo;
        seen_rfsh <= 1'b1;
      end
    end
  end

  assert_io_not_in_m1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && (!rd_n || !wr_n)) |-> m1_n);

  assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_refresh_under_mreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> (!mreq_n && rd_n && m1_n));

  assert_refresh_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rfsh_n && rfsh_q && seen_rfsh) |-> (addr_lo == last_rfsh + RFSH_W'(1)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_release_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_release && phase == PH_IDLE) |-> (!addr_oe && !strobe_oe && !data_oe));

  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TW && !wait_n) |=> (phase == PH_TW));

endmodule

bind bcs_bus_seq bcs_bus_seq_chk #(.RFSH_W(RFSH_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase       (phase_q),
  .wait_n      (wait_n),
  .bus_release (bus_release),
  .done        (done),
  .addr_lo     (addr_o[RFSH_W-1:0]),
  .addr_oe     (addr_oe),
  .strobe_oe   (strobe_oe),
  .data_oe     (data_oe),
  .mreq_n      (mreq_n),
  .iorq_n      (iorq_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .m1_n        (m1_n),
  .rfsh_n      (rfsh_n)
);

// File: tb/bcs_bus_seq_tb_top.sv
module bcs_bus_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [2:0]  cmd_kind;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_wdata;
  logic        done;
  logic [7:0]  rdata;
  logic        bus_release, wait_n;
  logic [7:0]  data_i;
  logic [15:0] addr_o;
  logic        addr_oe;
  logic [7:0]  data_o;
  logic        data_oe;
  logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, strobe_oe;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;
  logic [6:0]  rc = 7'd0;
  logic [15:0] last_addr = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcs_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .done(done), .rdata(rdata), .bus_release(bus_release), .wait_n(wait_n),
    .data_i(data_i), .addr_o(addr_o), .addr_oe(addr_oe), .data_o(data_o),
    .data_oe(data_oe), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .strobe_oe(strobe_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // active-high map {mreq, iorq, rd, wr, m1, rfsh}; phase 1=T1 2=T2 3=TW 4=T3 5=T4
  function automatic logic [5:0] exp_str(input int kind, input int ph);
    case (kind)
      0: return (ph <= 3) ? 6'b101010 : 6'b100001;
      1: return 6'b101000;
      2: return (ph == 1) ? 6'b100000 : 6'b100100;
      3: return (ph == 1) ? 6'b000000 : 6'b011000;
      4: return (ph == 1) ? 6'b000000 : 6'b010100;
      5: return (ph == 1) ? 6'b000010 : 6'b010010;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic string kind_req(input int kind, input int ph);
    if (ph == 3) return "R7";
    case (kind)
      0: return (ph <= 3) ? "R2" : "R3";
      1, 2: return "R4";
      3, 4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [5:0] act_str();
    return ~{mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n};
  endfunction

  task automatic run_cycle(input int kind, input logic [15:0] a,
                           input logic [7:0] wd, input int nwait,
                           input logic [7:0] rv);
    int n_ph;
    n_ph = 3 + nwait + ((kind == 1 || kind == 2) ? 0 : 1);
    data_i    = rv;
    cmd_kind  = 3'(kind);
    cmd_addr  = a;
    cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < n_ph; k++) begin
      int ph;
      logic [15:0] ea;
      logic        eoe;
      ph = (k == 0) ? 1 : (k == 1) ? 2 : (k <= 1 + nwait) ? 3 : (k == 2 + nwait) ? 4 : 5;
      chk(kind_req(kind, ph), "strobes", 32'(act_str()), 32'(exp_str(kind, ph)));
      ea = (kind == 0 && ph >= 4) ? {a[15:7], rc} : a;
      chk((kind == 0 && ph >= 4) ? "R3" : kind_req(kind, ph), "address", 32'(addr_o), 32'(ea));
      eoe = (kind == 2 && ph <= 4) || (kind == 4);
      chk((kind == 4) ? "R5" : "R4", "data_oe", 32'(data_oe), 32'(eoe));
      if (eoe) chk((kind == 4) ? "R5" : "R4", "data_o", 32'(data_o), 32'(wd));
      chk("R8", "done early", 32'(done), 32'd0);
      wait_n = !(k >= 1 && k <= nwait);
      @(posedge clk); @(negedge clk);
    end
    wait_n = 1'b1;
    chk("R8", "done pulse", 32'(done), 32'd1);
    chk("R8", "idle strobes", 32'(act_str()), 32'd0);
    chk("R8", "idle address", 32'(addr_o), 32'(a));
    if (kind == 0 || kind == 1 || kind == 3 || kind == 5)
      chk("R8", "rdata", 32'(rdata), 32'(rv));
    if (kind == 0) rc = rc + 7'd1;
    last_addr = a;
  endtask

  task automatic ignored_kind(input int kind);
    cmd_kind  = 3'(kind);
    cmd_addr  = 16'hBEEF;
    cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R10", "strobes after ignored kind", 32'(act_str()), 32'd0);
      chk("R10", "done after ignored kind", 32'(done), 32'd0);
      chk("R10", "address after ignored kind", 32'(addr_o), 32'(last_addr));
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 3'd0; cmd_addr = '0;
    cmd_wdata = '0; bus_release = 1'b0; wait_n = 1'b1; data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    chk("R1", "strobes", 32'({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}), 32'h3F);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "rdata", 32'(rdata), 32'd0);
    chk("R1", "addr_o", 32'(addr_o), 32'd0);
    chk("R1", "enables", 32'({addr_oe, strobe_oe, data_oe}), 32'b110);
    chk("R1", "cmd_ready", 32'(cmd_ready), 32'd1);

    // directed: every kind without waits, then with a long stall
    for (int k = 0; k < 6; k++) run_cycle(k, 16'h1280 + 16'(k), 8'h5A + 8'(k), 0, 8'hC0 + 8'(k));
    for (int k = 0; k < 6; k++) run_cycle(k, 16'hA3F1, 8'h3C, 9, 8'h81 + 8'(k));

    // R10 ignored codes
    ignored_kind(6);
    ignored_kind(7);

    // R9 bus release while idle
    bus_release = 1'b1;
    #1;
    chk("R9", "enables released", 32'({addr_oe, strobe_oe, data_oe}), 32'd0);
    chk("R9", "cmd_ready released", 32'(cmd_ready), 32'd0);
    cmd_kind = 3'd1; cmd_addr = 16'h7777; cmd_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R9", "no cycle under release", 32'(act_str()), 32'd0);
      chk("R9", "address enable off", 32'(addr_oe), 32'd0);
    end
    cmd_valid = 1'b0;
    bus_release = 1'b0;
    #1;
    chk("R9", "enables restored", 32'({addr_oe, strobe_oe}), 32'b11);

    // R3 refresh counter wrap: many fetches
    for (int i = 0; i < 130; i++) run_cycle(0, 16'(i * 97), 8'h00, i % 2, 8'(i));

    // random mix
    for (int i = 0; i < 250; i++) begin
      int kind, nw;
      kind = int'($urandom % 6);
      nw   = ($urandom % 3 == 0) ? int'($urandom % 5) : 0;
      run_cycle(kind, 16'($urandom), 8'($urandom), nw, 8'($urandom));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule